// File: doc/BRIEF.md
# Dual-IO Serial Flash Read Responder

This block is the memory-side read logic of a serial flash device, reduced to the dual-line fast read path. The block watches an active-low chip select and a serial clock. It samples both of them, along with two data lines, in its own system clock domain. It recognises the dual read opcode, which arrives one bit per serial clock on the first data line. It then takes in an address and a mode byte at two bits per serial clock. After that it streams bytes back at two bits per serial clock from a small internal byte array, and the address advances and wraps as it goes.

A mode byte whose upper nibble is Ah arms a continuous read state. In that state the following transactions start directly with the address phase and have no opcode. Any mode byte with a different upper nibble, such as the FFh reset pattern, disarms the state at the end of its transaction. A transaction that begins while the busy flag is high is ignored in full. A preload port lets a test environment fill the array one byte per system clock.

Top module: `dual_read_responder`

## Requirements
- R1: After reset both output enables are low and continuous read is off, so the first transaction must begin with an opcode.
- R2: With continuous read off, the opcode is taken MSb first on io0, one bit per rising SCK. It is followed by 12 rising edges of address bit pairs, then 4 rising edges of mode bit pairs. In every pair the more significant bit is on io1 and the next bit is on io0.
- R3: In the data phase each byte is sent as 4 bit pairs, MSb first. The higher bit of each pair is on io1 and the lower bit is on io0. Each pair is updated after a falling SCK edge. The first pair follows the falling edge right after the last mode pair, with no dummy cycles.
- R4: The byte address goes up by one after every fourth output pair. The array index is the low log2(DEPTH) bits of the address, so index DEPTH-1 is followed by index 0 and the higher address bits have no effect.
- R5: A completed mode byte whose upper nibble is Ah (lower nibble any value) makes the next transaction start at the address phase, with no opcode.
- R6: Continuous read persists across any number of transactions whose mode upper nibble is Ah. A completed mode byte with any other upper nibble, such as FFh, turns it off once CE# rises, so the next transaction needs the opcode again.
- R7: An opcode other than BBh (such as 03h or FFh) drives nothing for the rest of the transaction.
- R8: If busy is high when chip select falls, the transaction drives nothing and the continuous read state stays as it was.
- R9: The output enables are low during the opcode, address and mode phases. They fall within 3 system clocks of cs_n rising.
- R10: A preload write stores pl_data at index pl_addr, and later reads return it.
- R11: A transaction ended before its mode byte completes leaves the continuous read state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| io0_i | input | 1 | Data line 0 as driven by the host |
| io1_i | input | 1 | Data line 1 as driven by the host |
| io0_o | output | 1 | Data line 0 output value |
| io1_o | output | 1 | Data line 1 output value |
| io0_oe | output | 1 | Output enable for data line 0 |
| io1_oe | output | 1 | Output enable for data line 1 |
| busy | input | 1 | Device busy flag; a transaction that starts while it is high is ignored |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | log2(DEPTH) | Preload byte index |
| pl_data | input | 8 | Preload byte value |

## Verification
The bench reads across the top of the array and from addresses with nonzero high bits. An index that failed to wrap, or that kept the high bits, would return the wrong bytes there. It walks continuous read through several re-armed transactions, a busy transaction, an aborted transaction and a mode byte of FFh. A design that updated the mode state too early, or on an ignored or cut-short transaction, would then expect an opcode when none comes, or the reverse, and would read garbage. Unknown opcodes and busy starts must leave the lines released; a design that still decoded them would raise its enables. The first output pair is checked on the very first falling edge, so an extra dummy cycle or a swapped io1/io0 order shows up as byte mismatches.

// File: rtl/drr_pkg.sv
package drr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_MODE,
    ST_DATA,
    ST_DROP
  } drr_state_e;

  localparam logic [7:0] OPC_DUAL_READ = 8'hBB;
  localparam logic [3:0] CONT_KEY      = 4'hA;
  localparam int unsigned OPC_BITS     = 8;
  localparam int unsigned ADDR_PAIRS   = 12;
  localparam int unsigned MODE_PAIRS   = 4;
endpackage

// File: rtl/drr_rst_sync.sv
module drr_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_s = out_q;
endmodule

// File: rtl/drr_sync.sv
module drr_sync #(
  parameter int unsigned    W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        hold_q <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        hold_q <= meta_q;
      end
    end

    assign q[i] = hold_q;
  end
endmodule

// File: rtl/drr_array.sv
module drr_array #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/drr_ctrl.sv
module drr_ctrl
  import drr_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sck_s,
  input  logic          d0_s,
  input  logic          d1_s,
  input  logic          busy,
  input  logic          byte_done,
  output logic [AW-1:0] rd_addr,
  output logic          active,
  output logic          sck_fall
);
  drr_state_e    state_q, state_d;
  logic          cs_q;
  logic          sck_q;
  logic [3:0]    cnt_q, cnt_d;
  logic [7:0]    opc_q, opc_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [3:0]    mode_q, mode_d;
  logic          mode_ok_q, mode_ok_d;
  logic          cont_q, cont_d;
  logic          sck_rise;
  logic          cs_rise;
  logic [7:0]    opc_next;

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign cs_rise  = cs_s & ~cs_q;
  assign opc_next = {opc_q[6:0], d0_s};

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    opc_d     = opc_q;
    addr_d    = addr_q;
    mode_d    = mode_q;
    mode_ok_d = mode_ok_q;
    cont_d    = cont_q;
    if (cs_s) begin
      state_d   = ST_IDLE;
      cnt_d     = '0;
      mode_ok_d = 1'b0;
      if (cs_rise && mode_ok_q) begin
        cont_d = (mode_q == CONT_KEY);
      end
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_d = '0;
          if (busy)        state_d = ST_DROP;
          else if (cont_q) state_d = ST_ADDR;
          else             state_d = ST_OPC;
        end
        ST_OPC: begin
          if (sck_rise) begin
            opc_d = opc_next;
            cnt_d = cnt_q + 4'd1;
            if (cnt_q == 4'(OPC_BITS - 1)) begin
              cnt_d   = '0;
              state_d = (opc_next == OPC_DUAL_READ) ? ST_ADDR : ST_DROP;
            end
          end
        end
        ST_ADDR: begin
          if (sck_rise) begin
            addr_d = {addr_q[AW-3:0], d1_s, d0_s};
            cnt_d  = cnt_q + 4'd1;
            if (cnt_q == 4'(ADDR_PAIRS - 1)) begin
              cnt_d   = '0;
              state_d = ST_MODE;
            end
          end
        end
        ST_MODE: begin
          if (sck_rise) begin
            if (cnt_q < 4'd2) begin
              mode_d = {mode_q[1:0], d1_s, d0_s};
            end
            cnt_d = cnt_q + 4'd1;
            if (cnt_q == 4'(MODE_PAIRS - 1)) begin
              cnt_d     = '0;
              mode_ok_d = 1'b1;
              state_d   = ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (byte_done) begin
            addr_d = addr_q + 1'b1;
          end
        end
        default: begin
          state_d = ST_DROP;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cs_q      <= 1'b1;
      sck_q     <= 1'b0;
      cnt_q     <= '0;
      opc_q     <= '0;
      addr_q    <= '0;
      mode_q    <= '0;
      mode_ok_q <= 1'b0;
      cont_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      cs_q      <= cs_s;
      sck_q     <= sck_s;
      cnt_q     <= cnt_d;
      opc_q     <= opc_d;
      addr_q    <= addr_d;
      mode_q    <= mode_d;
      mode_ok_q <= mode_ok_d;
      cont_q    <= cont_d;
    end
  end

  assign rd_addr = addr_q;
  assign active  = (state_q == ST_DATA) && !cs_s;

  // R4
  wrap_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (addr_q == AW'(DEPTH - 1))) |=> (addr_q == '0));

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !cs_s && busy) |=> (state_q == ST_DROP));

  // R11
  cont_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(cont_q));

  // R2
  mode_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_DATA) |-> ($past(state_q) == ST_MODE));
endmodule

// File: rtl/drr_serializer.sv
module drr_serializer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       sck_fall,
  input  logic [7:0] rd_data,
  output logic       pair_hi,
  output logic       pair_lo,
  output logic       drive_en,
  output logic       byte_done
);
  logic [7:0] sh_q, sh_d;
  logic [1:0] pcnt_q, pcnt_d;
  logic [1:0] out_q, out_d;
  logic       oe_q, oe_d;
  logic       act_q;
  logic       reload_q;

  assign byte_done = active && sck_fall && (pcnt_q == 2'd3);

  always_comb begin
    sh_d   = sh_q;
    pcnt_d = pcnt_q;
    out_d  = out_q;
    oe_d   = oe_q;
    if (!active) begin
      oe_d   = 1'b0;
      pcnt_d = '0;
    end else if (!act_q || reload_q) begin
      sh_d = rd_data;
    end else if (sck_fall) begin
      out_d  = sh_q[7:6];
      sh_d   = {sh_q[5:0], 2'b00};
      pcnt_d = pcnt_q + 2'd1;
      oe_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      pcnt_q   <= '0;
      out_q    <= '0;
      oe_q     <= 1'b0;
      act_q    <= 1'b0;
      reload_q <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      pcnt_q   <= pcnt_d;
      out_q    <= out_d;
      oe_q     <= oe_d;
      act_q    <= active;
      reload_q <= byte_done;
    end
  end

  assign pair_hi  = out_q[1];
  assign pair_lo  = out_q[0];
  assign drive_en = oe_q && active;

  // R3
  reload_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_q |-> (pcnt_q == 2'd0));
endmodule

// File: rtl/dual_read_responder.sv
module dual_read_responder #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          io0_i,
  input  logic          io1_i,
  output logic          io0_o,
  output logic          io1_o,
  output logic          io0_oe,
  output logic          io1_oe,
  input  logic          busy,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [7:0]    pl_data
);
  logic          rst_n_s;
  logic [3:0]    pins_s;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          active;
  logic          sck_fall;
  logic          byte_done;
  logic          drive_en;

  drr_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  drr_sync #(.W(4), .RST_VAL(4'b0001)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     ({io1_i, io0_i, sck, cs_n}),
    .q     (pins_s)
  );

  drr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cs_s      (pins_s[0]),
    .sck_s     (pins_s[1]),
    .d0_s      (pins_s[2]),
    .d1_s      (pins_s[3]),
    .busy      (busy),
    .byte_done (byte_done),
    .rd_addr   (rd_addr),
    .active    (active),
    .sck_fall  (sck_fall)
  );

  drr_array #(.DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .wr_en   (pl_we),
    .wr_addr (pl_addr),
    .wr_data (pl_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  drr_serializer u_ser (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .active    (active),
    .sck_fall  (sck_fall),
    .rd_data   (rd_data),
    .pair_hi   (io1_o),
    .pair_lo   (io0_o),
    .drive_en  (drive_en),
    .byte_done (byte_done)
  );

  assign io0_oe = drive_en;
  assign io1_oe = drive_en;

  // R9
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(io0_oe) |-> $past(sck_fall));
endmodule

// File: tb/dual_read_responder_bench.sv
module dual_read_responder_bench;
  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);
  localparam int H     = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n, sck, io0_i, io1_i, busy, pl_we;
  logic [AW-1:0] pl_addr;
  logic [7:0]    pl_data;
  logic          io0_o, io1_o, io0_oe, io1_oe;

  logic [7:0] mem_ref [DEPTH];
  bit         cont_ref;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  dual_read_responder #(.DEPTH(DEPTH)) u_dual_read_responder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .io0_i(io0_i), .io1_i(io1_i), .io0_o(io0_o), .io1_o(io1_o),
    .io0_oe(io0_oe), .io1_oe(io1_oe), .busy(busy),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_byte(input logic [23:0] adr, input int k);
    return mem_ref[(int'(adr[AW-1:0]) + k) % DEPTH];
  endfunction

  task automatic preload(input int idx, input logic [7:0] val);
    pl_we   = 1'b1;
    pl_addr = AW'(idx);
    pl_data = val;
    tick(1);
    pl_we = 1'b0;
    mem_ref[idx] = val;
  endtask

  task automatic pair_in(input logic b1, input logic b0, inout bit seen_oe);
    sck = 1'b0; io1_i = b1; io0_i = b0;
    tick(H);
    seen_oe |= (io0_oe | io1_oe);
    sck = 1'b1;
    tick(H);
    seen_oe |= (io0_oe | io1_oe);
  endtask

  task automatic xfer(input bit send_opc, input logic [7:0] opc,
                      input logic [23:0] adr, input logic [7:0] mode,
                      input int nbytes, input int cut, input string tag);
    bit seen_oe = 1'b0;
    bit full    = (cut == 0);
    bit drives  = !busy && full && (!send_opc || opc == 8'hBB);
    bit oe_bad  = 1'b0;
    logic [7:0] got;
    cs_n = 1'b0;
    tick(H);
    if (send_opc) for (int i = 0; i < 8; i++) pair_in(1'b0, opc[7-i], seen_oe);
    for (int i = 0; i < 12; i++) begin
      if (!full && i == cut) break;
      pair_in(adr[23-2*i], adr[22-2*i], seen_oe);
    end
    if (full) for (int i = 0; i < 4; i++) pair_in(mode[7-2*i], mode[6-2*i], seen_oe);
    // R9: enables stay low before the data phase
    check(!seen_oe, {tag, " R9"}, "oe before data", int'(seen_oe), 0);
    if (full) begin
      for (int b = 0; b < nbytes; b++) begin
        got = '0;
        for (int p = 0; p < 4; p++) begin
          sck = 1'b0;
          tick(H);
          got = {got[5:0], io1_o, io0_o};
          if ((io0_oe & io1_oe) != drives) oe_bad = 1'b1;
          sck = 1'b1;
          tick(H);
        end
        // R3 R4: byte value and address progression
        if (drives) check(got == ref_byte(adr, b), {tag, " R3 R4"}, "data byte",
                          int'(got), int'(ref_byte(adr, b)));
      end
      // R7 R8: no drive when ignored; drive during every pair otherwise
      check(!oe_bad, {tag, " R7 R8"}, "oe in data window", int'(oe_bad), 0);
    end
    cs_n = 1'b1;
    tick(3);
    // R9: release after chip select rises
    check(!(io0_oe | io1_oe), {tag, " R9"}, "oe after cs rise", int'(io0_oe | io1_oe), 0);
    sck = 1'b0;
    tick(H);
    if (drives) cont_ref = (mode[7:4] == 4'hA);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed_word;
    seed_word = $urandom(32'h5EED);
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; io0_i = 1'b0; io1_i = 1'b0;
    busy = 1'b0; pl_we = 1'b0; pl_addr = '0; pl_data = '0;
    cont_ref = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R1: enables low after reset
    check(!(io0_oe | io1_oe), "R1", "oe after reset", int'(io0_oe | io1_oe), 0);
    for (int i = 0; i < DEPTH; i++) preload(i, 8'($urandom));

    // R1 R2: first transaction carries the opcode
    xfer(1'b1, 8'hBB, 24'h000010, 8'h00, 3, 0, "R1 R2");
    // R4: wrap at the top of the array and high address bits ignored
    xfer(1'b1, 8'hBB, 24'h0000FE, 8'h3C, 4, 0, "R4 wrap");
    xfer(1'b1, 8'hBB, 24'hAB00FF, 8'h00, 2, 0, "R4 high bits");
    // R5: enter continuous read
    xfer(1'b1, 8'hBB, 24'h000020, 8'hA5, 2, 0, "R5 enter");
    xfer(1'b0, 8'h00, 24'h000040, 8'hA0, 3, 0, "R5 R6 no opcode");
    // R8: busy start is ignored and keeps the state
    busy = 1'b1;
    xfer(1'b0, 8'h00, 24'h000050, 8'h00, 2, 0, "R8 busy cont");
    busy = 1'b0;
    // R11: aborted before the mode byte
    xfer(1'b0, 8'h00, 24'h000060, 8'h00, 0, 5, "R11 abort");
    xfer(1'b0, 8'h00, 24'h000070, 8'hAF, 2, 0, "R6 R11 still cont");
    // R6: mode reset pattern ends continuous read
    xfer(1'b0, 8'h00, 24'hFFFFFF, 8'hFF, 2, 0, "R6 reset");
    check(cont_ref == 1'b0, "R6", "model state after FFh", int'(cont_ref), 0);
    xfer(1'b1, 8'hBB, 24'h000080, 8'h00, 2, 0, "R6 opcode again");
    // R7: unknown opcodes
    xfer(1'b1, 8'h03, 24'h000010, 8'h00, 2, 0, "R7 op03");
    xfer(1'b1, 8'hFF, 24'h000010, 8'h00, 2, 0, "R7 opFF");
    xfer(1'b1, 8'hBB, 24'h000011, 8'h00, 1, 0, "R7 after unknown");
    // R8: busy in normal mode
    busy = 1'b1;
    xfer(1'b1, 8'hBB, 24'h000012, 8'hA0, 2, 0, "R8 busy");
    busy = 1'b0;
    xfer(1'b1, 8'hBB, 24'h000012, 8'h00, 1, 0, "R8 after busy");
    // R10: preload overwrite then read back
    preload(8'h33, 8'h5A);
    xfer(1'b1, 8'hBB, 24'h000033, 8'h00, 1, 0, "R10 preload");

    for (int t = 0; t < 40; t++) begin
      logic [23:0] a;
      logic [7:0]  m;
      int          nb, cut;
      a    = 24'($urandom);
      m    = ($urandom % 2) ? {4'hA, 4'($urandom)} : 8'($urandom);
      nb   = 1 + ($urandom % 5);
      cut  = (($urandom % 10) == 0) ? 1 + ($urandom % 11) : 0;
      busy = (($urandom % 8) == 0);
      xfer(!cont_ref, 8'hBB, a, m, nb, cut, "R5 R6 random");
      busy = 1'b0;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule